// File: doc/BRIEF.md
# Dual 8/16-bit compare timer

This block is a counter made of two 8-bit halves, a low half and a high half. Each half has its own compare register. A mode input chooses how the halves work. In split mode they count as two independent 8-bit up-counters. In cascade mode the low half's carry feeds the high half, so together they form one 16-bit counter that is compared against both compare registers at once.

Counting advances only on a single-cycle `tick` strobe. A byte-wide control/status register holds, for each half, four bits:
- an overflow flag,
- a compare-match flag,
- an overflow interrupt enable,
- a clear-on-match enable.

A flag can be cleared only through a two-step exchange with software. First the status register must be read while the flag is 1. Then a 0 must be written to that bit. The block drives one overflow interrupt request line per half.

A simple synchronous register bus reaches the counters, the compare registers and the status register. Reads return data combinationally. Writes land on the next clock edge.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, both counters, both compare registers and every status bit read as 0, and both interrupt lines are low.
- R2: Register map: address 0 is the low counter, 1 is the high counter, 2 is the low compare, 3 is the high compare, 4 is status. Status bits from 7 down to 0 are: high overflow flag, high compare flag, high overflow enable, high clear enable, low overflow flag, low compare flag, low overflow enable, low clear enable.
- R3: In split mode, a tick that moves a half from 0xFF to 0x00 sets that half's overflow flag.
- R4: A tick taken while a half's count equals its compare value sets that half's compare flag.
- R5: With the clear enable set, the tick taken at a matching count loads 0 instead of incrementing. A match at 0xFF that clears does not count as an overflow. With the clear enable at 0, a match leaves counting unchanged.
- R6: A flag clears only when 0 is written to its bit after a status read returned it as 1. Writing 0 without that prior read, or writing 1, leaves the flag unchanged.
- R7: If a hardware set of a flag coincides with its clearing write, the flag stays 1.
- R8: Each interrupt line is high exactly while that half's overflow flag and overflow enable are both 1.
- R9: In cascade mode, the low half's wrap increments the high half, and the high overflow flag sets on the 16-bit wrap. The high compare flag sets on a full 16-bit match. The high clear enable clears both halves, and the low clear enable has no effect. The low flags still follow the low half alone.
- R10: A counter write takes effect at the next clock and replaces that cycle's tick increment. In cascade mode, a write to either counter suppresses the whole 16-bit increment.
- R11: Compare registers and the four enable bits read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe, one cycle wide |
| mode16 | input | 1 | 1 = cascaded 16-bit counter, 0 = two 8-bit counters |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flag clearing) |
| bus_wdata | input | HALF_W | Write data |
| bus_rdata | output | HALF_W | Read data for the addressed register |
| irq_ovf_lo | output | 1 | Low-half overflow interrupt request |
| irq_ovf_hi | output | 1 | High-half overflow interrupt request |

## Verification
The bench targets the edges where the halves meet:
- A clearing match at 0xFF. A design that also counts this as a wrap would raise a false overflow.
- A cascade carry into the high half. A design that ignores mode would leave the high half idle.
- A 16-bit match under the high clear enable. A design that compares only one byte would clear early, or not at all.

It also probes the flag exchange:
- A blind write of 0 must leave the flag set. A design without the read arming would drop the flag.
- A write of 1 must not set a flag.
- A clear that collides with a hardware set must keep the flag. Wrong priority would lose an overflow event.

Finally, a counter write on a tick cycle must land without a one-count overshoot.

// File: rtl/dct_pkg.sv
package dct_pkg;
   // register addresses
   localparam int unsigned A_CNT_LO = 0;
   localparam int unsigned A_CNT_HI = 1;
   localparam int unsigned A_CMP_LO = 2;
   localparam int unsigned A_CMP_HI = 3;
   localparam int unsigned A_STAT   = 4;

   // status bit positions
   localparam int unsigned SB_OVF_HI = 7;
   localparam int unsigned SB_CMF_HI = 6;
   localparam int unsigned SB_IEN_HI = 5;
   localparam int unsigned SB_CLR_HI = 4;
   localparam int unsigned SB_OVF_LO = 3;
   localparam int unsigned SB_CMF_LO = 2;
   localparam int unsigned SB_IEN_LO = 1;
   localparam int unsigned SB_CLR_LO = 0;

   localparam int unsigned NUM_FLAGS = 4;

   // flag index 0..3 -> status bit: cmf_lo, ovf_lo, cmf_hi, ovf_hi
   function automatic int unsigned flag_pos(input int unsigned idx);
      return (idx % 2) + 2 + (idx / 2) * 4;
   endfunction
endpackage

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic rd_hit,
   input  logic wr_hit,
   input  logic wr_bit,
   output logic flag
);
   logic armed;
   logic clr_req;

   assign clr_req = wr_hit && !wr_bit && armed;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         armed <= 1'b0;
      end else begin
         if (hw_set)       flag <= 1'b1;
         else if (clr_req) flag <= 1'b0;

         if (clr_req)             armed <= 1'b0;
         else if (rd_hit && flag) armed <= 1'b1;
      end
   end
endmodule

// File: rtl/tmr_counter_pair.sv
module tmr_counter_pair #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         mode16,
   input  logic         wr_lo,
   input  logic         wr_hi,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] cmp_lo,
   input  logic [W-1:0] cmp_hi,
   input  logic         clr_en_lo,
   input  logic         clr_en_hi,
   output logic [W-1:0] cnt_lo,
   output logic [W-1:0] cnt_hi,
   output logic         ev_ovf_lo,
   output logic         ev_cmf_lo,
   output logic         ev_ovf_hi,
   output logic         ev_cmf_hi
);
   localparam logic [W-1:0] ONE = W'(1);

   logic match_lo, match_hi, full_lo, full_hi;
   logic adv_lo, adv_hi, wipe_lo, wipe_hi, carry_hi;
   logic [W-1:0] nxt_lo, nxt_hi;

   always_comb begin
      match_lo = (cnt_lo == cmp_lo);
      match_hi = (cnt_hi == cmp_hi);
      full_lo  = &cnt_lo;
      full_hi  = &cnt_hi;
      if (mode16) begin
         adv_lo    = tick && !wr_lo && !wr_hi;
         adv_hi    = adv_lo;
         wipe_lo   = adv_lo && clr_en_hi && match_lo && match_hi;
         wipe_hi   = wipe_lo;
         carry_hi  = full_lo;
         ev_cmf_lo = adv_lo && match_lo;
         ev_cmf_hi = adv_lo && match_lo && match_hi;
         ev_ovf_lo = adv_lo && full_lo && !wipe_lo;
         ev_ovf_hi = ev_ovf_lo && full_hi;
      end else begin
         adv_lo    = tick && !wr_lo;
         adv_hi    = tick && !wr_hi;
         wipe_lo   = adv_lo && clr_en_lo && match_lo;
         wipe_hi   = adv_hi && clr_en_hi && match_hi;
         carry_hi  = 1'b1;
         ev_cmf_lo = adv_lo && match_lo;
         ev_cmf_hi = adv_hi && match_hi;
         ev_ovf_lo = adv_lo && full_lo && !wipe_lo;
         ev_ovf_hi = adv_hi && full_hi && !wipe_hi;
      end

      if (wr_lo)        nxt_lo = wdata;
      else if (wipe_lo) nxt_lo = '0;
      else if (adv_lo)  nxt_lo = cnt_lo + ONE;
      else              nxt_lo = cnt_lo;

      if (wr_hi)                   nxt_hi = wdata;
      else if (wipe_hi)            nxt_hi = '0;
      else if (adv_hi && carry_hi) nxt_hi = cnt_hi + ONE;
      else                         nxt_hi = cnt_hi;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_lo <= '0;
         cnt_hi <= '0;
      end else begin
         cnt_lo <= nxt_lo;
         cnt_hi <= nxt_hi;
      end
   end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
   import dct_pkg::*;
#(
   parameter int unsigned HALF_W = 8,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              mode16,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [HALF_W-1:0] bus_wdata,
   output logic [HALF_W-1:0] bus_rdata,
   output logic              irq_ovf_lo,
   output logic              irq_ovf_hi
);
   localparam int unsigned STAT_W = 8;

   generate
      if (HALF_W < STAT_W) begin : g_bad_width
         $error("HALF_W must hold the 8-bit status register");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must reach address 4");
      end
   endgenerate

   logic sel_cnt_lo, sel_cnt_hi, sel_cmp_lo, sel_cmp_hi, sel_stat;
   assign sel_cnt_lo = (bus_addr == ADDR_W'(A_CNT_LO));
   assign sel_cnt_hi = (bus_addr == ADDR_W'(A_CNT_HI));
   assign sel_cmp_lo = (bus_addr == ADDR_W'(A_CMP_LO));
   assign sel_cmp_hi = (bus_addr == ADDR_W'(A_CMP_HI));
   assign sel_stat   = (bus_addr == ADDR_W'(A_STAT));

   logic [HALF_W-1:0] cmp_lo, cmp_hi, cnt_lo, cnt_hi;
   logic ien_lo, ien_hi, clr_lo, clr_hi;
   logic ev_ovf_lo, ev_cmf_lo, ev_ovf_hi, ev_cmf_hi;
   logic [NUM_FLAGS-1:0] flag_evt, flag_q;
   logic [STAT_W-1:0] stat_vec;

   // compare and enable registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_lo <= '0;
         cmp_hi <= '0;
         ien_lo <= 1'b0;
         ien_hi <= 1'b0;
         clr_lo <= 1'b0;
         clr_hi <= 1'b0;
      end else if (bus_wr) begin
         if (sel_cmp_lo) cmp_lo <= bus_wdata;
         if (sel_cmp_hi) cmp_hi <= bus_wdata;
         if (sel_stat) begin
            ien_lo <= bus_wdata[SB_IEN_LO];
            ien_hi <= bus_wdata[SB_IEN_HI];
            clr_lo <= bus_wdata[SB_CLR_LO];
            clr_hi <= bus_wdata[SB_CLR_HI];
         end
      end
   end

   tmr_counter_pair #(.W(HALF_W)) cnt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .mode16    (mode16),
      .wr_lo     (bus_wr && sel_cnt_lo),
      .wr_hi     (bus_wr && sel_cnt_hi),
      .wdata     (bus_wdata),
      .cmp_lo    (cmp_lo),
      .cmp_hi    (cmp_hi),
      .clr_en_lo (clr_lo),
      .clr_en_hi (clr_hi),
      .cnt_lo    (cnt_lo),
      .cnt_hi    (cnt_hi),
      .ev_ovf_lo (ev_ovf_lo),
      .ev_cmf_lo (ev_cmf_lo),
      .ev_ovf_hi (ev_ovf_hi),
      .ev_cmf_hi (ev_cmf_hi)
   );

   assign flag_evt = {ev_ovf_hi, ev_cmf_hi, ev_ovf_lo, ev_cmf_lo};

   for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
      localparam int unsigned POS = flag_pos(gi);
      tmr_flag_cell flag_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .hw_set (flag_evt[gi]),
         .rd_hit (bus_rd && sel_stat),
         .wr_hit (bus_wr && sel_stat),
         .wr_bit (bus_wdata[POS]),
         .flag   (flag_q[gi])
      );
   end

   assign stat_vec = {flag_q[3], flag_q[2], ien_hi, clr_hi,
                      flag_q[1], flag_q[0], ien_lo, clr_lo};

   always_comb begin
      bus_rdata = '0;
      if (sel_cnt_lo)      bus_rdata = cnt_lo;
      else if (sel_cnt_hi) bus_rdata = cnt_hi;
      else if (sel_cmp_lo) bus_rdata = cmp_lo;
      else if (sel_cmp_hi) bus_rdata = cmp_hi;
      else if (sel_stat)   bus_rdata = HALF_W'(stat_vec);
   end

   assign irq_ovf_lo = flag_q[1] && ien_lo;
   assign irq_ovf_hi = flag_q[3] && ien_hi;
endmodule

// File: rtl/dual_cmp_timer_chk.sv
module dual_cmp_timer_chk #(
   parameter int unsigned W      = 8,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              mode16,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [W-1:0]      bus_wdata,
   input logic [W-1:0]      cnt_lo,
   input logic [W-1:0]      cnt_hi,
   input logic [W-1:0]      cmp_lo,
   input logic [W-1:0]      cmp_hi,
   input logic [7:0]        stat_vec,
   input logic              irq_ovf_lo,
   input logic              irq_ovf_hi
);
   logic wr_clo, wr_chi, wr_st;
   assign wr_clo = bus_wr && (bus_addr == ADDR_W'(0));
   assign wr_chi = bus_wr && (bus_addr == ADDR_W'(1));
   assign wr_st  = bus_wr && (bus_addr == ADDR_W'(4));

   a_r10_cnt_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clo |=> cnt_lo == $past(bus_wdata));

   a_r5_clear_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode16 && tick && !wr_clo && stat_vec[0] && cnt_lo == cmp_lo) |=> cnt_lo == '0);

   a_r3_ovf_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode16 && tick && !wr_clo && (&cnt_lo) && !(stat_vec[0] && cnt_lo == cmp_lo))
      |=> stat_vec[3]);

   a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_vec[3] && !wr_st) |=> stat_vec[3]);

   a_r8_irq_hi: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ovf_hi |-> (stat_vec[7] && stat_vec[5]));

   a_r8_irq_lo: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ovf_lo |-> (stat_vec[3] && stat_vec[1]));

   a_r9_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (mode16 && tick && !wr_clo && !wr_chi && (&cnt_lo)
       && !(stat_vec[4] && cnt_lo == cmp_lo && cnt_hi == cmp_hi))
      |=> cnt_hi == $past(cnt_hi) + W'(1));
endmodule

bind dual_cmp_timer dual_cmp_timer_chk #(.W(HALF_W), .ADDR_W(ADDR_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick       (tick),
   .mode16     (mode16),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .cnt_lo     (cnt_lo),
   .cnt_hi     (cnt_hi),
   .cmp_lo     (cmp_lo),
   .cmp_hi     (cmp_hi),
   .stat_vec   (stat_vec),
   .irq_ovf_lo (irq_ovf_lo),
   .irq_ovf_hi (irq_ovf_hi)
);

// File: tb/dual_cmp_timer_tb_top.sv
module dual_cmp_timer_tb_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic mode16 = 1'b0;
   logic [2:0] bus_addr = '0;
   logic bus_wr = 1'b0;
   logic bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic irq_ovf_lo, irq_ovf_hi;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_cmp_timer dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode16(mode16),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_ovf_lo(irq_ovf_lo), .irq_ovf_hi(irq_ovf_hi)
   );

   // {cmp_lo, start, clr_en, ticks, exp_cnt, exp_status_low_nibble}
   localparam logic [47:0] VEC [5] = '{
      {8'h10, 8'h0E, 8'h00, 8'd4, 8'h12, 8'h04},
      {8'h10, 8'h0E, 8'h01, 8'd4, 8'h01, 8'h05},
      {8'h05, 8'hFD, 8'h00, 8'd4, 8'h01, 8'h08},
      {8'hFF, 8'hFE, 8'h01, 8'd3, 8'h01, 8'h05},
      {8'h30, 8'h20, 8'h00, 8'd2, 8'h22, 8'h00}
   };

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; mode16 = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      tick = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
   endtask

   initial begin
      logic [7:0] d;
      do_reset();

      // R1: reset state
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), d);
         check("R1 reset reg", d, 8'h00);
      end
      check("R1 irq lo", {7'd0, irq_ovf_lo}, 8'h00);
      check("R1 irq hi", {7'd0, irq_ovf_hi}, 8'h00);

      // vector table, split mode: R3 R4 R5
      for (int i = 0; i < 5; i++) begin
         do_reset();
         wr(3'd2, VEC[i][47:40]);
         wr(3'd0, VEC[i][39:32]);
         wr(3'd4, VEC[i][31:24]);
         ticks(int'(VEC[i][23:16]));
         rd(3'd0, d);
         check("R5 vector count", d, VEC[i][15:8]);
         rd(3'd4, d);
         check("R3/R4 vector flags", d & 8'h0F, VEC[i][7:0]);
      end

      // R11 and R2: compare and enable readback, write 1 to flags ignored (R6)
      do_reset();
      wr(3'd3, 8'hA5);
      rd(3'd3, d);
      check("R11 cmp hi readback", d, 8'hA5);
      wr(3'd4, 8'h33);
      rd(3'd4, d);
      check("R2 enable layout", d, 8'h33);
      wr(3'd4, 8'hFF);
      rd(3'd4, d);
      check("R6 write one no set", d, 8'h33);

      // R6: blind clear ignored, armed clear works
      do_reset();
      wr(3'd0, 8'hFF);
      ticks(1);
      wr(3'd4, 8'h00);
      rd(3'd4, d);
      check("R6 blind write keeps flag", d & 8'h08, 8'h08);
      wr(3'd4, 8'h00);
      rd(3'd4, d);
      check("R6 armed clear", d & 8'h08, 8'h00);

      // R8: interrupt line
      do_reset();
      wr(3'd4, 8'h02);
      wr(3'd0, 8'hFF);
      ticks(1);
      check("R8 irq lo raised", {7'd0, irq_ovf_lo}, 8'h01);
      check("R8 irq hi quiet", {7'd0, irq_ovf_hi}, 8'h00);
      rd(3'd4, d);
      wr(3'd4, 8'h02);
      check("R8 irq lo dropped", {7'd0, irq_ovf_lo}, 8'h00);

      // R7: set beats clear
      do_reset();
      wr(3'd0, 8'hFF);
      ticks(1);
      rd(3'd4, d);
      wr(3'd0, 8'hFF);
      bus_addr = 3'd4; bus_wdata = 8'h00; bus_wr = 1'b1; tick = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0; tick = 1'b0;
      rd(3'd4, d);
      check("R7 set wins", d & 8'h08, 8'h08);

      // R10: write replaces tick
      do_reset();
      bus_addr = 3'd0; bus_wdata = 8'h40; bus_wr = 1'b1; tick = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0; tick = 1'b0;
      rd(3'd0, d);
      check("R10 write lands", d, 8'h40);
      ticks(1);
      rd(3'd0, d);
      check("R10 next tick", d, 8'h41);

      // R9: cascade carry and 16-bit overflow
      do_reset();
      mode16 = 1'b1;
      wr(3'd0, 8'hFF);
      wr(3'd1, 8'h12);
      ticks(1);
      rd(3'd1, d);
      check("R9 carry into high", d, 8'h13);
      rd(3'd0, d);
      check("R9 low wrapped", d, 8'h00);
      rd(3'd4, d);
      check("R9 low ovf only", d & 8'h88, 8'h08);
      wr(3'd0, 8'hFF);
      wr(3'd1, 8'hFF);
      ticks(1);
      rd(3'd4, d);
      check("R9 16-bit ovf", d & 8'h80, 8'h80);

      // R9: 16-bit clear on match
      do_reset();
      mode16 = 1'b1;
      wr(3'd2, 8'h34);
      wr(3'd3, 8'h02);
      wr(3'd4, 8'h10);
      wr(3'd0, 8'h33);
      wr(3'd1, 8'h02);
      ticks(2);
      rd(3'd0, d);
      check("R9 clear16 low", d, 8'h00);
      rd(3'd1, d);
      check("R9 clear16 high", d, 8'h00);
      rd(3'd4, d);
      check("R9 cmp16 flag", d & 8'h40, 8'h40);

      // R9: low clear enable ignored in cascade mode
      do_reset();
      mode16 = 1'b1;
      wr(3'd2, 8'h05);
      wr(3'd3, 8'h07);
      wr(3'd4, 8'h01);
      wr(3'd0, 8'h05);
      ticks(1);
      rd(3'd0, d);
      check("R9 low clear ignored", d, 8'h06);
      rd(3'd4, d);
      check("R9 low cmp flag", d & 8'h44, 8'h04);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule